// File: doc/BRIEF.md
# CAN Bit Stuffer and Destuffer

This unit sits between the frame sequencer and the bit-timing logic of a CAN controller and handles both directions of bit stuffing. Both directions move one bit at each bit-time strobe. On the transmit side it takes frame bits from an upstream source. Once five equal bits have gone out inside the stuffing region, it sends one bit of the opposite level. During that strobe it pulls its ready output low, so the upstream source holds its current bit for the next strobe.

On the receive side it takes the sampled bus level at each strobe and passes payload bits downstream with a one-cycle valid pulse. After five equal bits it drops the next bit, so stuff bits never reach the CRC logic. If that dropped bit has the same level as the run, the unit raises a one-cycle stuff-error pulse instead.

A region input marks the span from the start-of-frame bit to the last CRC bit. Outside that span bits pass straight through and nothing is counted. A stuff bit owed after the final bit of the region is still sent on the transmit side and still removed on the receive side. In both directions the stuff bit counts as the first bit of a new run.

Top module: `can_stuff_unit`

## Requirements
- R1: The unit acts only when `tick` is high. Its registered outputs take their new value at the clock edge that samples `tick` high. `rx_valid` and `rx_stuff_err` are high for that one cycle only, and `tx_line` holds its value between strobes.
- R2: With `region_on` high, after five consecutive transmitted bits of equal level the next strobe sends the complement of that level on `tx_line`. During that strobe `tx_ready` is low and the upstream bit is not consumed.
- R3: A transmitted stuff bit is the first bit of a new run. For example, input 000001111 must go out as 00000 1 1111 0, with a second stuff bit after four more 1s.
- R4: The input stream 0000000111110001 (first bit leftmost) must be sent as 000001001111100001.
- R5: A strobe with `region_on` low sends `tx_bit_in` unchanged with `tx_ready` high and clears the run count. The first bit after region entry starts a run of one.
- R6: If the last bit inside the region completes a run of five, the next strobe still sends the stuff bit with `tx_ready` low, even when `region_on` is already low.
- R7: On receive, after five equal sampled bits, the next sampled bit is dropped (no `rx_valid`). When its level is the opposite one, no error is raised. So 000001001111100001 is delivered as 0000000111110001.
- R8: On receive, a sixth consecutive equal bit inside the region produces one `rx_stuff_err` pulse and no `rx_valid` on that strobe.
- R9: On receive, with `region_on` low, every sampled bit is delivered with `rx_valid` and no run is counted, so long runs raise no error.
- R10: After reset `tx_line` is 1 (recessive), `tx_ready` is 1, and `rx_valid` and `rx_stuff_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Bit-time strobe, one cycle per bit |
| region_on | input | 1 | High while the current bit lies in the stuffed span |
| tx_bit_in | input | 1 | Next frame bit from the upstream source |
| tx_ready | output | 1 | High when the current strobe consumes `tx_bit_in` |
| tx_line | output | 1 | Bit driven toward the bus |
| rx_sample | input | 1 | Sampled bus level at the strobe |
| rx_bit_out | output | 1 | Destuffed payload bit |
| rx_valid | output | 1 | One-cycle pulse marking a payload bit |
| rx_stuff_err | output | 1 | One-cycle pulse on a run of six equal bits |

## Verification
A transmit-side stuff insertion and a receive-side stuff error can occur on the same strobe, because both directions share one tick. The bench provokes this by driving six 0s into both sides at once inside the region. On the sixth strobe it requires all of the following together: `tx_ready` low with a 1 on `tx_line`, an error pulse, and no valid pulse. This shows that neither side's run counter interferes with the other.

// File: rtl/can_stuff_unit.sv
module can_stuff_unit #(
  parameter int RUN_LIMIT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic region_on,
  input  logic tx_bit_in,
  output logic tx_ready,
  output logic tx_line,
  input  logic rx_sample,
  output logic rx_bit_out,
  output logic rx_valid,
  output logic rx_stuff_err
);
  localparam int CW = $clog2(RUN_LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(RUN_LIMIT);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          rx_last;
  logic          tx_stuff, rx_drop;

  assign tx_stuff = (tx_cnt == LIM);
  assign rx_drop  = (rx_cnt == LIM);
  assign tx_ready = !tx_stuff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_line <= 1'b1;
      tx_cnt  <= '0;
    end else if (tick) begin
      if (tx_stuff) begin
        tx_line <= !tx_line;
        tx_cnt  <= ONE;
      end else begin
        tx_line <= tx_bit_in;
        if (!region_on)
          tx_cnt <= '0;
        else if (tx_cnt != '0 && tx_bit_in == tx_line)
          tx_cnt <= tx_cnt + ONE;
        else
          tx_cnt <= ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_cnt       <= '0;
      rx_last      <= 1'b1;
      rx_bit_out   <= 1'b1;
      rx_valid     <= 1'b0;
      rx_stuff_err <= 1'b0;
    end else begin
      rx_valid     <= 1'b0;
      rx_stuff_err <= 1'b0;
      if (tick) begin
        rx_last <= rx_sample;
        if (rx_drop) begin
          rx_stuff_err <= (rx_sample == rx_last);
          rx_cnt       <= ONE;
        end else begin
          rx_valid   <= 1'b1;
          rx_bit_out <= rx_sample;
          if (!region_on)
            rx_cnt <= '0;
          else if (rx_cnt != '0 && rx_sample == rx_last)
            rx_cnt <= rx_cnt + ONE;
          else
            rx_cnt <= ONE;
        end
      end
    end
  end
endmodule

// File: rtl/can_stuff_chk.sv
module can_stuff_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic tx_ready,
  input logic tx_line,
  input logic rx_valid,
  input logic rx_stuff_err
);
  a_r1_line_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(tx_line));
  a_r1_valid_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid || rx_stuff_err) |-> $past(tick));
  a_r2_stuff_flips_line: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !tx_ready) |=> (tx_line != $past(tx_line)));
  a_r3_single_stuff: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !tx_ready) |=> tx_ready);
  a_r8_err_excludes_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && rx_stuff_err));
endmodule

bind can_stuff_unit can_stuff_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .tx_ready(tx_ready),
  .tx_line(tx_line), .rx_valid(rx_valid), .rx_stuff_err(rx_stuff_err)
);

// File: tb/tb_can_stuff_unit.sv
module tb_can_stuff_unit;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, region_on = 1'b0;
  logic tx_bit_in = 1'b1, rx_sample = 1'b1;
  logic tx_ready, tx_line, rx_bit_out, rx_valid, rx_stuff_err;
  int checks = 0, fails = 0;

  always #5 clk = !clk;

  can_stuff_unit dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // entered and left at a negedge
  task automatic step(input logic reg_on, input logic tb, input logic rb,
                      output logic rdy, output logic line, output logic v,
                      output logic b, output logic e);
    region_on = reg_on; tx_bit_in = tb; rx_sample = rb; tick = 1'b1;
    rdy = tx_ready;
    @(posedge clk); @(negedge clk);
    tick = 1'b0;
    line = tx_line; v = rx_valid; b = rx_bit_out; e = rx_stuff_err;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic clear_runs();
    logic r, l, v, b, e;
    step(1'b0, 1'b1, 1'b1, r, l, v, b, e);
  endtask

  task automatic t_reset();
    chk(tx_line == 1'b1, "R10 tx_line", tx_line, 1);
    chk(tx_ready == 1'b1, "R10 tx_ready", tx_ready, 1);
    chk(rx_valid == 1'b0, "R10 rx_valid", rx_valid, 0);
    chk(rx_stuff_err == 1'b0, "R10 rx_stuff_err", rx_stuff_err, 0);
  endtask

  task automatic t_pulse();
    logic r, l, v, b, e;
    step(1'b0, 1'b0, 1'b0, r, l, v, b, e);
    chk(v == 1'b1, "R1 valid on tick", v, 1);
    chk(rx_valid == 1'b0, "R1 valid one cycle", rx_valid, 0);
    repeat (3) @(negedge clk);
    chk(tx_line == 1'b0, "R1 line held", tx_line, 0);
    clear_runs();
  endtask

  task automatic t_example_tx();
    logic [15:0] din = 16'b0000000111110001;
    logic [17:0] dexp = 18'b000001001111100001;
    int idx = 0, stuffs = 0;
    logic r, l, v, b, e;
    for (int n = 0; n < 18; n++) begin
      step(1'b1, idx < 16 ? din[15-idx] : 1'b1, 1'b1, r, l, v, b, e);
      if (r) idx++; else stuffs++;
      chk(l == dexp[17-n], "R4 tx stream bit", l, dexp[17-n]);
    end
    chk(stuffs == 2, "R2 stuff count", stuffs, 2);
    chk(idx == 16, "R2 bits consumed", idx, 16);
    clear_runs();
  endtask

  task automatic t_run_restart();
    logic [8:0] din = 9'b000001111;
    logic [10:0] dexp = 11'b00000111110;
    int idx = 0;
    logic r, l, v, b, e;
    for (int n = 0; n < 11; n++) begin
      step(1'b1, idx < 9 ? din[8-idx] : 1'b1, 1'b1, r, l, v, b, e);
      if (r) idx++;
      chk(l == dexp[10-n], "R3 tx bit", l, dexp[10-n]);
      if (n == 10) chk(r == 1'b0, "R3 second stuff ready", r, 0);
    end
    clear_runs();
  endtask

  task automatic t_outside_tx();
    logic r, l, v, b, e;
    for (int n = 0; n < 7; n++) begin
      step(1'b0, 1'b0, 1'b1, r, l, v, b, e);
      chk(r == 1'b1 && l == 1'b0, "R5 pass-through tx", {r, l}, 2);
    end
    for (int n = 0; n < 5; n++) begin
      step(1'b1, 1'b0, 1'b1, r, l, v, b, e);
      chk(r == 1'b1, "R5 fresh run after entry", r, 1);
    end
    step(1'b1, 1'b0, 1'b1, r, l, v, b, e);
    chk(r == 1'b0 && l == 1'b1, "R5 stuff after five", {r, l}, 1);
    clear_runs();
  endtask

  task automatic t_tail_stuff();
    logic r, l, v, b, e;
    for (int n = 0; n < 5; n++) step(1'b1, 1'b1, 1'b1, r, l, v, b, e);
    step(1'b0, 1'b1, 1'b1, r, l, v, b, e);
    chk(r == 1'b0, "R6 tail stuff ready", r, 0);
    chk(l == 1'b0, "R6 tail stuff level", l, 0);
    step(1'b0, 1'b1, 1'b1, r, l, v, b, e);
    chk(r == 1'b1 && l == 1'b1, "R6 after tail stuff", {r, l}, 3);
    clear_runs();
  endtask

  task automatic t_example_rx();
    logic [17:0] din = 18'b000001001111100001;
    logic [15:0] dexp = 16'b0000000111110001;
    int got = 0, errs = 0;
    logic r, l, v, b, e;
    for (int n = 0; n < 18; n++) begin
      step(1'b1, 1'b1, din[17-n], r, l, v, b, e);
      if (e) errs++;
      if (v) begin
        if (got < 16) chk(b == dexp[15-got], "R7 rx payload bit", b, dexp[15-got]);
        got++;
      end
    end
    chk(got == 16, "R7 rx payload count", got, 16);
    chk(errs == 0, "R7 no error on valid stuff", errs, 0);
    clear_runs();
  endtask

  task automatic t_rx_error();
    logic r, l, v, b, e;
    for (int n = 0; n < 5; n++) begin
      step(1'b1, 1'b1, 1'b0, r, l, v, b, e);
      chk(v == 1'b1 && e == 1'b0, "R8 first five delivered", {v, e}, 2);
    end
    step(1'b1, 1'b1, 1'b0, r, l, v, b, e);
    chk(e == 1'b1 && v == 1'b0, "R8 sixth equal bit", {v, e}, 1);
    chk(rx_stuff_err == 1'b0, "R8 error one cycle", rx_stuff_err, 0);
    clear_runs();
  endtask

  task automatic t_outside_rx();
    logic r, l, v, b, e;
    for (int n = 0; n < 8; n++) begin
      step(1'b0, 1'b1, 1'b0, r, l, v, b, e);
      chk(v == 1'b1 && e == 1'b0 && b == 1'b0, "R9 rx pass-through", {v, e, b}, 4);
    end
    clear_runs();
  endtask

  task automatic t_collision();
    logic r, l, v, b, e;
    for (int n = 0; n < 5; n++) step(1'b1, 1'b0, 1'b0, r, l, v, b, e);
    step(1'b1, 1'b0, 1'b0, r, l, v, b, e);
    chk(r == 1'b0 && l == 1'b1, "R2 stuff with rx error", {r, l}, 1);
    chk(e == 1'b1 && v == 1'b0, "R8 error with tx stuff", {v, e}, 1);
    clear_runs();
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pulse();
    t_example_tx();
    t_run_restart();
    t_outside_tx();
    t_tail_stuff();
    t_example_rx();
    t_rx_error();
    t_outside_rx();
    t_collision();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule